// File: doc/BRIEF.md
# Segment Selector Translator

This block turns a two-part logical address, a 16-bit selector plus a 32-bit offset, into a 32-bit linear address. It holds two descriptor-table registers, a base and a limit each: one for the global table and one for the local table. When a new selector is loaded, the block checks that the whole 8-byte entry lies inside the chosen table. It then reads the entry through a simple request/acknowledge memory port, as two 32-bit words. It decodes base, effective limit, privilege and presence into a hidden cache register. Each later access needs no memory traffic: the offset is checked against the cached limit and privilege and is then added to the cached base.

A controller drives three states. ST_IDLE accepts loads and accesses. ST_FETCH_LO holds the read of the first descriptor word. ST_FETCH_HI holds the read of the second word. The transitions are: ST_IDLE to ST_FETCH_LO on a selector load that fits the table, ST_FETCH_LO to ST_FETCH_HI on the first acknowledge, and ST_FETCH_HI to ST_IDLE on the second acknowledge. A load that falls outside its table faults and stays in ST_IDLE. Faults are single-cycle pulses with a code, so the surrounding pipeline can raise its own exception.

Top module: `seg_xlate`

## Requirements
- R1: Selector bits 15:3 are the index, bit 2 picks the table (0 global, 1 local), bits 1:0 are the requestor privilege. The two reads go to table base + index*8 and then to that address + 4.
- R2: Once mem_req is high, it and mem_addr stay unchanged until mem_ack is seen high.
- R3: A load whose index*8+7 exceeds the chosen table limit gives fault with code 1 on the next cycle and issues no read. The boundary case index*8+7 equal to the limit is accepted.
- R4: Descriptor layout. The first word holds limit[15:0] in bits 15:0 and base[15:0] in bits 31:16. The second word holds base[23:16] in bits 7:0, the privilege level in bits 14:13, present in bit 15, limit[19:16] in bits 19:16, granularity in bit 23 and base[31:24] in bits 31:24.
- R5: A descriptor with present = 0 gives fault code 2 in the cycle after the second acknowledge, and leaves no usable descriptor.
- R6: An access accepted in ST_IDLE gives exactly one of lin_valid or fault one cycle later. lin_addr = base + offset, modulo 2^32.
- R7: The effective limit is the 20-bit limit when granularity is 0, and limit*4096 + 4095 when it is 1. An offset above the effective limit gives fault code 3 and no lin_valid. An offset equal to the limit passes.
- R8: An access whose privilege, the larger of cur_priv and the requestor field saved at load, is numerically above the descriptor level gives fault code 4. Code 3 takes precedence over code 4.
- R9: Accesses after a successful load issue no memory reads and are unaffected by later writes to the table registers.
- R10: An access with no valid cached descriptor (before any load, or after a failed one) gives fault code 5. An access while busy, or in the same cycle as a load, gives neither lin_valid nor fault.
- R11: After reset, busy, mem_req, lin_valid and fault are 0 and no descriptor is cached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_wr_en | input | 1 | Write a table register pair |
| tbl_wr_local | input | 1 | 0 writes the global table, 1 the local table |
| tbl_wr_base | input | 32 | Table base to write |
| tbl_wr_limit | input | TLIM_W | Table byte limit to write |
| sel_load | input | 1 | Load a new selector |
| sel_value | input | 16 | Selector to load |
| acc_valid | input | 1 | Translate an offset |
| acc_offset | input | 32 | Offset within the segment |
| cur_priv | input | 2 | Current privilege level |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor read address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| busy | output | 1 | Descriptor fetch in progress |
| lin_valid | output | 1 | Linear address valid pulse |
| lin_addr | output | 32 | Linear address |
| fault | output | 1 | Fault pulse |
| fault_code | output | 3 | 1 table, 2 absent, 3 limit, 4 privilege, 5 no descriptor |

## Verification
Access results appear one cycle after the accepting edge. The bench drives on the falling edge and samples at the next falling edge. A table fault is also due one cycle after the load edge, before any request. A fetch result is due in the cycle where busy drops, so the bench polls busy on falling edges and reads fault in that same sample. Request addresses and the hold rule are logged on falling edges, where mem_req and mem_ack are settled for the coming edge.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int LIN_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_FETCH_LO = 2'd1,
        ST_FETCH_HI = 2'd2
    } xl_state_t;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_TABLE  = 3'd1,
        FLT_ABSENT = 3'd2,
        FLT_LIMIT  = 3'd3,
        FLT_PRIV   = 3'd4,
        FLT_NODESC = 3'd5
    } flt_code_t;

    typedef struct packed {
        logic [LIN_W-1:0] base;
        logic [LIN_W-1:0] eff_limit;
        logic [1:0]       dpl;
        logic             present;
    } desc_t;

endpackage

// File: rtl/seg_tbl_regs.sv
module seg_tbl_regs #(
    parameter int TLIM_W = 16,
    parameter int NTBL   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     wr_sel,
    input  logic [31:0]              wr_base,
    input  logic [TLIM_W-1:0]        wr_limit,
    input  logic                     rd_sel,
    output logic [31:0]              rd_base,
    output logic [TLIM_W-1:0]        rd_limit
);

    logic [31:0]       base_q  [NTBL];
    logic [TLIM_W-1:0] limit_q [NTBL];

    for (genvar t = 0; t < NTBL; t++) begin : g_tbl
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[t]  <= '0;
                limit_q[t] <= '0;
            end else if (wr_en && (int'(wr_sel) == t)) begin
                base_q[t]  <= wr_base;
                limit_q[t] <= wr_limit;
            end
        end
    end

    assign rd_base  = base_q[rd_sel];
    assign rd_limit = limit_q[rd_sel];

endmodule

// File: rtl/seg_desc_decode.sv
module seg_desc_decode
    import seg_xlate_pkg::*;
(
    input  logic [31:0] word_lo,
    input  logic [31:0] word_hi,
    output desc_t       desc
);

    localparam int PAGE_SH = 12;

    logic [19:0] raw_limit;
    logic        gran;

    always_comb begin
        raw_limit       = {word_hi[19:16], word_lo[15:0]};
        gran            = word_hi[23];
        desc.base       = {word_hi[31:24], word_hi[7:0], word_lo[31:16]};
        desc.eff_limit  = gran ? {raw_limit, {PAGE_SH{1'b1}}}
                               : {{PAGE_SH{1'b0}}, raw_limit};
        desc.dpl        = word_hi[14:13];
        desc.present    = word_hi[15];
    end

endmodule

// File: rtl/seg_access_chk.sv
module seg_access_chk
    import seg_xlate_pkg::*;
(
    input  desc_t             cache,
    input  logic              cache_ok,
    input  logic [LIN_W-1:0]  offset,
    input  logic [1:0]        cur_priv,
    input  logic [1:0]        req_priv,
    output flt_code_t         code,
    output logic [LIN_W-1:0]  lin
);

    logic [1:0] eff_priv;

    always_comb begin
        eff_priv = (cur_priv > req_priv) ? cur_priv : req_priv;
        lin      = cache.base + offset;
        if (!cache_ok)
            code = FLT_NODESC;
        else if (offset > cache.eff_limit)
            code = FLT_LIMIT;
        else if (eff_priv > cache.dpl)
            code = FLT_PRIV;
        else
            code = FLT_NONE;
    end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int TLIM_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_wr_en,
    input  logic              tbl_wr_local,
    input  logic [31:0]       tbl_wr_base,
    input  logic [TLIM_W-1:0] tbl_wr_limit,
    input  logic              sel_load,
    input  logic [15:0]       sel_value,
    input  logic              acc_valid,
    input  logic [31:0]       acc_offset,
    input  logic [1:0]        cur_priv,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              busy,
    output logic              lin_valid,
    output logic [31:0]       lin_addr,
    output logic              fault,
    output logic [2:0]        fault_code
);

    localparam int IDX_W   = 13;
    localparam int ENT_SH  = 3;
    localparam int SPAN_W  = IDX_W + ENT_SH;
    localparam int CMP_W   = (SPAN_W > TLIM_W) ? SPAN_W + 1 : TLIM_W + 1;
    localparam int WORD_B  = 4;

    xl_state_t         state_q, state_d;
    logic [31:0]       fetch_addr_q;
    logic [31:0]       lo_q;
    desc_t             cache_q;
    logic              cache_ok_q;
    logic [1:0]        rpl_q;
    logic              lin_valid_q;
    logic [31:0]       lin_addr_q;
    logic              fault_q;
    flt_code_t         code_q;

    logic [IDX_W-1:0]  sel_idx;
    logic              sel_tbl;
    logic [1:0]        sel_rpl;
    logic [31:0]       tbl_base;
    logic [TLIM_W-1:0] tbl_limit;
    logic [CMP_W-1:0]  span_end;
    logic              tbl_over;
    desc_t             dec;
    flt_code_t         acc_code;
    logic [31:0]       acc_lin;

    assign sel_idx  = sel_value[15:3];
    assign sel_tbl  = sel_value[2];
    assign sel_rpl  = sel_value[1:0];
    assign span_end = CMP_W'({sel_idx, {ENT_SH{1'b1}}});
    assign tbl_over = span_end > CMP_W'(tbl_limit);

    seg_tbl_regs #(.TLIM_W(TLIM_W), .NTBL(2)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_wr_en),
        .wr_sel   (tbl_wr_local),
        .wr_base  (tbl_wr_base),
        .wr_limit (tbl_wr_limit),
        .rd_sel   (sel_tbl),
        .rd_base  (tbl_base),
        .rd_limit (tbl_limit)
    );

    seg_desc_decode u_dec (
        .word_lo (lo_q),
        .word_hi (mem_rdata),
        .desc    (dec)
    );

    seg_access_chk u_chk_acc (
        .cache    (cache_q),
        .cache_ok (cache_ok_q),
        .offset   (acc_offset),
        .cur_priv (cur_priv),
        .req_priv (rpl_q),
        .code     (acc_code),
        .lin      (acc_lin)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (sel_load && !tbl_over) state_d = ST_FETCH_LO;
            ST_FETCH_LO: if (mem_ack)               state_d = ST_FETCH_HI;
            ST_FETCH_HI: if (mem_ack)               state_d = ST_IDLE;
            default:                                state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_addr_q <= '0;
            lo_q         <= '0;
            cache_q      <= '0;
            cache_ok_q   <= 1'b0;
            rpl_q        <= '0;
            lin_valid_q  <= 1'b0;
            lin_addr_q   <= '0;
            fault_q      <= 1'b0;
            code_q       <= FLT_NONE;
        end else begin
            lin_valid_q <= 1'b0;
            fault_q     <= 1'b0;
            code_q      <= FLT_NONE;
            unique case (state_q)
                ST_IDLE: begin
                    if (sel_load) begin
                        cache_ok_q   <= 1'b0;
                        rpl_q        <= sel_rpl;
                        fetch_addr_q <= tbl_base + {16'd0, sel_idx, {ENT_SH{1'b0}}};
                        if (tbl_over) begin
                            fault_q <= 1'b1;
                            code_q  <= FLT_TABLE;
                        end
                    end else if (acc_valid) begin
                        if (acc_code == FLT_NONE) begin
                            lin_valid_q <= 1'b1;
                            lin_addr_q  <= acc_lin;
                        end else begin
                            fault_q <= 1'b1;
                            code_q  <= acc_code;
                        end
                    end
                end
                ST_FETCH_LO: begin
                    if (mem_ack) begin
                        lo_q         <= mem_rdata;
                        fetch_addr_q <= fetch_addr_q + 32'(WORD_B);
                    end
                end
                ST_FETCH_HI: begin
                    if (mem_ack) begin
                        if (!dec.present) begin
                            fault_q <= 1'b1;
                            code_q  <= FLT_ABSENT;
                        end else begin
                            cache_q    <= dec;
                            cache_ok_q <= 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy       = (state_q != ST_IDLE);
    assign mem_req    = busy;
    assign mem_addr   = fetch_addr_q;
    assign lin_valid  = lin_valid_q;
    assign lin_addr   = lin_addr_q;
    assign fault      = fault_q;
    assign fault_code = code_q;

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sel_load,
    input logic        acc_valid,
    input logic        busy,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_ack,
    input logic        lin_valid,
    input logic        fault,
    input logic [2:0]  fault_code,
    input logic        tbl_over
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R2

    AST_TABLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && sel_load && tbl_over |=> fault && fault_code == 3'd1 && !mem_req); // R3

    AST_ACC_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !sel_load && acc_valid |=> lin_valid != fault); // R6

    AST_LIN_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        lin_valid |-> $past(acc_valid) && !$past(busy) && !$past(sel_load)); // R6

    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !mem_ack |=> !lin_valid && !fault); // R10

    AST_FAULT_CODED: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> fault_code != 3'd0 && !lin_valid); // R7

endmodule

bind seg_xlate seg_xlate_chk u_seg_xlate_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_load   (sel_load),
    .acc_valid  (acc_valid),
    .busy       (busy),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .lin_valid  (lin_valid),
    .fault      (fault),
    .fault_code (fault_code),
    .tbl_over   (tbl_over)
);

// File: tb/seg_xlate_bench.sv
`timescale 1ns/1ps
module seg_xlate_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_wr_en = 1'b0, tbl_wr_local = 1'b0;
    logic [31:0] tbl_wr_base = '0;
    logic [15:0] tbl_wr_limit = '0;
    logic        sel_load = 1'b0;
    logic [15:0] sel_value = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_offset = '0;
    logic [1:0]  cur_priv = '0;
    logic        mem_req, mem_ack;
    logic [31:0] mem_addr, mem_rdata;
    logic        busy, lin_valid, fault;
    logic [31:0] lin_addr;
    logic [2:0]  fault_code;

    int total = 0, bad = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    seg_xlate u_seg_xlate (
        .clk(clk), .rst_n(rst_n),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_local(tbl_wr_local),
        .tbl_wr_base(tbl_wr_base), .tbl_wr_limit(tbl_wr_limit),
        .sel_load(sel_load), .sel_value(sel_value),
        .acc_valid(acc_valid), .acc_offset(acc_offset), .cur_priv(cur_priv),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .busy(busy), .lin_valid(lin_valid), .lin_addr(lin_addr),
        .fault(fault), .fault_code(fault_code)
    );

    // memory model: 128 words, acknowledge after two wait cycles
    logic [31:0] mem_words [0:127];
    logic [1:0]  wcnt;
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0; wcnt <= '0; mem_rdata <= '0;
        end else if (mem_req && !mem_ack) begin
            if (wcnt == 2'd2) begin
                mem_ack   <= 1'b1;
                mem_rdata <= mem_words[mem_addr[8:2]];
                wcnt      <= '0;
            end else wcnt <= wcnt + 2'd1;
        end else mem_ack <= 1'b0;
    end

    // request monitor on falling edges
    int          ack_cnt = 0, hold_bad = 0;
    logic [31:0] addr_a = '0, addr_b = '0, prev_addr = '0;
    logic        pend = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (pend && (!mem_req || mem_addr != prev_addr)) hold_bad = hold_bad + 1;
            pend      = mem_req && !mem_ack;
            prev_addr = mem_addr;
            if (mem_req && mem_ack) begin
                if (ack_cnt % 2 == 0) addr_a = mem_addr; else addr_b = mem_addr;
                ack_cnt = ack_cnt + 1;
            end
        end
    end

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tbl_write(input logic loc, input logic [31:0] b, input logic [15:0] l);
        @(negedge clk);
        tbl_wr_en = 1'b1; tbl_wr_local = loc; tbl_wr_base = b; tbl_wr_limit = l;
        @(negedge clk);
        tbl_wr_en = 1'b0;
    endtask

    task automatic put_desc(input int w, input logic [31:0] b, input logic [19:0] l,
                            input logic g, input logic [1:0] d, input logic p);
        mem_words[w]   = {b[15:0], l[15:0]};
        mem_words[w+1] = {b[31:24], g, 1'b1, 2'b00, l[19:16], p, d, 1'b1, 4'h2, b[23:16]};
    endtask

    task automatic do_load(input logic [15:0] s, output logic [2:0] code);
        @(negedge clk);
        sel_load = 1'b1; sel_value = s;
        @(negedge clk);
        sel_load = 1'b0;
        for (int i = 0; i < 40 && busy; i++) @(negedge clk);
        code = fault ? fault_code : 3'd0;
    endtask

    task automatic do_acc(input logic [31:0] off, input logic [1:0] cp,
                          output logic lv, output logic [31:0] la, output logic [2:0] fc);
        @(negedge clk);
        acc_valid = 1'b1; acc_offset = off; cur_priv = cp;
        @(negedge clk);
        acc_valid = 1'b0;
        lv = lin_valid;
        la = lin_addr;
        fc = fault ? fault_code : 3'd0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic        lv;
        logic [31:0] la;
        logic [2:0]  fc, lc;
        int          acks0;

        for (int i = 0; i < 128; i++) mem_words[i] = '0;
        repeat (3) @(negedge clk);
        // R11 reset state
        check(!busy && !mem_req && !lin_valid && !fault, "R11 reset outputs",
              {busy, mem_req, lin_valid, fault}, 0);
        rst_n = 1'b1;
        do_acc(32'h10, 2'd0, lv, la, fc);
        check(!lv && fc == 3'd5, "R11 R10 no descriptor after reset", fc, 5);

        tbl_write(1'b0, 32'h0,   16'h003F);
        tbl_write(1'b1, 32'h100, 16'h001F);

        // R4 field layout with distinct bytes
        put_desc(2, 32'hA1B2C3D4, 20'h56789, 1'b0, 2'd3, 1'b1);
        do_load({13'd1, 1'b0, 2'b00}, lc);
        check(lc == 3'd0, "R4 load ok", lc, 0);
        check(addr_a == 32'h8 && addr_b == 32'hC, "R1 global read addresses", addr_a, 32'h8);
        do_acc(32'h56789, 2'd3, lv, la, fc);
        check(lv && la == 32'hA1B2C3D4 + 32'h56789, "R4 R6 base/limit at boundary", la, 32'hA1B2C3D4 + 32'h56789);
        do_acc(32'h5678A, 2'd3, lv, la, fc);
        check(!lv && fc == 3'd3, "R4 R7 one past limit", fc, 3);

        // R9 cache reuse
        acks0 = ack_cnt;
        tbl_write(1'b0, 32'h40, 16'h003F);
        do_acc(32'h100, 2'd1, lv, la, fc);
        check(lv && la == 32'hA1B2C3D4 + 32'h100, "R9 table rewrite no effect", la, 32'hA1B2C3D4 + 32'h100);
        check(ack_cnt == acks0, "R9 no reads on access", ack_cnt, acks0);
        tbl_write(1'b0, 32'h0, 16'h003F);

        // R3 table limit faults
        @(negedge clk);
        sel_load = 1'b1; sel_value = {13'd8, 1'b0, 2'b00};
        @(negedge clk);
        sel_load = 1'b0;
        check(fault && fault_code == 3'd1 && !mem_req, "R3 global index over limit", fault_code, 1);
        do_acc(32'h0, 2'd0, lv, la, fc);
        check(!lv && fc == 3'd5, "R10 access after table fault", fc, 5);
        do_load({13'd4, 1'b1, 2'b00}, lc);
        check(lc == 3'd1, "R3 local index over limit", lc, 1);
        put_desc(64 + 6, 32'h00500000, 20'h00FFF, 1'b0, 2'd0, 1'b1);
        do_load({13'd3, 1'b1, 2'b00}, lc);
        check(lc == 3'd0, "R3 last entry accepted", lc, 0);
        check(addr_a == 32'h118 && addr_b == 32'h11C, "R1 local read addresses", addr_a, 32'h118);

        // R8 requestor field weakens privilege
        do_load({13'd3, 1'b1, 2'b11}, lc);
        do_acc(32'h0, 2'd0, lv, la, fc);
        check(!lv && fc == 3'd4, "R8 requestor field raises level", fc, 4);
        do_acc(32'h1000, 2'd3, lv, la, fc);
        check(!lv && fc == 3'd3, "R8 limit precedes privilege", fc, 3);

        // R5 absent descriptor
        put_desc(8, 32'h1234, 20'h10, 1'b0, 2'd3, 1'b0);
        do_load({13'd4, 1'b0, 2'b00}, lc);
        check(lc == 3'd2, "R5 absent fault", lc, 2);
        do_acc(32'h0, 2'd3, lv, la, fc);
        check(!lv && fc == 3'd5, "R5 no usable descriptor", fc, 5);

        // R10 access during fetch
        put_desc(64 + 4, 32'h7000, 20'h20, 1'b0, 2'd3, 1'b1);
        @(negedge clk);
        sel_load = 1'b1; sel_value = {13'd2, 1'b1, 2'b00};
        @(negedge clk);
        sel_load = 1'b0; acc_valid = 1'b1; acc_offset = 32'h4;
        @(negedge clk);
        acc_valid = 1'b0;
        check(!lin_valid && !fault, "R10 access while busy ignored", {lin_valid, fault}, 0);
        for (int i = 0; i < 40 && busy; i++) @(negedge clk);
        check(!fault, "R10 load completes", fault_code, 0);
        @(negedge clk);
        sel_load = 1'b1; acc_valid = 1'b1; sel_value = {13'd2, 1'b1, 2'b00};
        @(negedge clk);
        sel_load = 1'b0; acc_valid = 1'b0;
        check(!lin_valid && !fault, "R10 access with load ignored", {lin_valid, fault}, 0);
        for (int i = 0; i < 40 && busy; i++) @(negedge clk);

        // sweep: table x granularity x level x privilege x offset
        for (int t = 0; t < 2; t++) begin
            for (int g = 0; g < 2; g++) begin
                for (int d = 0; d < 4; d++) begin
                    logic [31:0] b, tb, eff;
                    logic [19:0] l;
                    logic [31:0] offs [3];
                    b   = 32'h1000_0000 * d + 32'h123 * g + 32'h40000 * t;
                    l   = 20'h00010 + 20'(d);
                    tb  = t ? 32'h100 : 32'h0;
                    eff = g ? {l, 12'hFFF} : {12'h0, l};
                    put_desc(int'(tb >> 2) + 2 * d, b, l, g[0], d[1:0], 1'b1);
                    do_load({13'(d), t[0], 2'b00}, lc);
                    check(lc == 3'd0 && addr_a == tb + 32'(8 * d) && addr_b == tb + 32'(8 * d + 4),
                          "R1 sweep load address", addr_a, tb + 32'(8 * d));
                    offs[0] = 32'h0; offs[1] = eff; offs[2] = eff + 32'h1;
                    for (int c = 0; c < 4; c++) begin
                        for (int k = 0; k < 3; k++) begin
                            logic [2:0] ec;
                            ec = (offs[k] > eff) ? 3'd3 : ((c > d) ? 3'd4 : 3'd0);
                            do_acc(offs[k], c[1:0], lv, la, fc);
                            if (ec == 3'd0)
                                check(lv && fc == 3'd0 && la == b + offs[k], "R6 R7 sweep translate", la, b + offs[k]);
                            else if (ec == 3'd3)
                                check(!lv && fc == 3'd3, "R7 sweep limit fault", fc, 3);
                            else
                                check(!lv && fc == 3'd4, "R8 sweep privilege fault", fc, 4);
                        end
                    end
                end
            end
        end

        check(hold_bad == 0, "R2 request held until ack", hold_bad, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule